// File: doc/BRIEF.md
# Super I/O Configuration Unlock Gate

This block is the configuration-space front end of a legacy Super I/O device. A host reaches it through two adjacent byte ports on a small I/O bus: an index port at the decoded base address and a data port at base plus one. A strap input picks which of two base addresses the device answers on, 0x2E or 0x4E. After reset the configuration space is closed. The host opens it by writing a four-byte key to the index port. The last byte of that key depends on the selected base.

While the space is open, the host writes a register number to the index port. It then reads or writes that register through the data port. The space holds identification bytes, a logical-device selector, a global flash control byte, and a banked pair of registers that set the flash controller's 16-bit I/O base. The banked pair is visible only while the selector holds the flash bank number. Writing a value with bit 1 set to register 0x02 closes the space again.

The block drives its stored settings (logical device, flash control byte, flash I/O base and the open flag) as registered outputs to the logic that sits behind it. Read data is registered and appears one cycle after the read strobe.

Top module: `sio_cfg_gate`

## Requirements
- R1: After reset the space is closed (cfg_open low), the selector reads 0x00, flash_ctl equals CTL_INIT and flash_base equals FBASE_INIT.
- R2: Four consecutive index-port writes of 0x87, 0x01, 0x55 and a final byte open the space; cfg_open is high in the cycle after the final write. The final byte is 0x55 when base_sel is 0 (base 0x2E) and 0xAA when base_sel is 1 (base 0x4E).
- R3: A key whose final byte is the value belonging to the other base_sel setting leaves the space closed.
- R4: An index-port write that breaks the key returns the matcher to its start. A breaking byte of 0x87 is taken as the first key byte, so 0x87,0x01,0x87,0x01,0x55,<final> opens the space.
- R5: While closed, data-port writes change no stored setting, and reads of either port return 0xFF.
- R6: While open, data reads of registers 0x20, 0x21 and 0x22 return ID_HI, ID_LO and REV_ID.
- R7: While open, register 0x07 is the logical-device selector: it reads back what was written and drives ldn_sel.
- R8: Registers 0x64 (high byte) and 0x65 (low byte) set flash_base. They can be written and read only while the selector equals FLASH_LDN (7). Under any other selector, writes to them are ignored and they read 0x00.
- R9: Register 0x24 is an 8-bit read/write control byte that drives flash_ctl: bit 0 suspend, bits 1 to 3 segment enables, bit 4 bus write enable, bit 5 pin select.
- R10: A data write to register 0x02 with bit 1 set closes the space in the next cycle. A write to 0x02 with bit 1 clear has no effect.
- R11: Accesses to any address other than the selected base and base+1 are ignored, and reads of them return 0xFF.
- R12: io_rdata changes only in the cycle after an io_rd strobe and otherwise holds its value.
- R13: While open, a read of the index port returns the last register number written there. Unimplemented register numbers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 1 | Base strap: 0 selects 0x2E, 1 selects 0x4E |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | Configuration space open |
| ldn_sel | output | 8 | Selected logical device |
| flash_ctl | output | 8 | Global flash control byte |
| flash_base | output | 16 | Flash controller I/O base |

## Verification
The hardest state to reach is a key matcher sitting midway through a partial key when a breaking byte arrives. The case that matters most is a breaking 0x87, which must count as a fresh first step and not send the matcher to idle. The stimulus interleaves broken and repeated prefixes and a key ending in the wrong final byte for the current strap. It then flips the strap and checks that each final byte unlocks only on its own base. A behavioural model keeps a sliding history of locked index writes and is compared with the outputs on every clock, so any mismatch in the matcher's restart behaviour shows up at once.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] REG_LOCK   = 8'h02;
  localparam logic [7:0] REG_LDN    = 8'h07;
  localparam logic [7:0] REG_ID_HI  = 8'h20;
  localparam logic [7:0] REG_ID_LO  = 8'h21;
  localparam logic [7:0] REG_REV    = 8'h22;
  localparam logic [7:0] REG_FCTL   = 8'h24;
  localparam logic [7:0] REG_FB_HI  = 8'h64;
  localparam logic [7:0] REG_FB_LO  = 8'h65;

  localparam logic [7:0] KEY_B0     = 8'h87;
  localparam logic [7:0] KEY_B1     = 8'h01;
  localparam logic [7:0] KEY_B2     = 8'h55;
  localparam logic [7:0] KEY_LAST_A = 8'h55;
  localparam logic [7:0] KEY_LAST_B = 8'hAA;

  localparam logic [7:0] RD_IDLE    = 8'hFF;
  localparam int         LOCK_BIT   = 1;

  typedef enum logic [1:0] {
    KS_WAIT0 = 2'd0,
    KS_WAIT1 = 2'd1,
    KS_WAIT2 = 2'd2,
    KS_WAIT3 = 2'd3
  } key_step_e;
endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode
  import sio_cfg_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter logic [7:0] BASE_A = 8'h2E,
  parameter logic [7:0] BASE_B = 8'h4E
) (
  input  logic              base_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_idx,
  output logic              hit_dat
);
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_A);
  localparam logic [ADDR_W-1:0] IDX_B = ADDR_W'(BASE_B);
  localparam logic [ADDR_W-1:0] DAT_A = IDX_A + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DAT_B = IDX_B + ADDR_W'(1);

  logic [ADDR_W-1:0] idx_addr;
  logic [ADDR_W-1:0] dat_addr;

  always_comb begin
    idx_addr = base_sel ? IDX_B : IDX_A;
    dat_addr = base_sel ? DAT_B : DAT_A;
    hit_idx  = (addr == idx_addr);
    hit_dat  = (addr == dat_addr);
  end
endmodule

// File: rtl/sio_key_seq.sv
module sio_key_seq
  import sio_cfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_we,
  input  logic [DATA_W-1:0] key_byte,
  input  logic              alt_base,
  output logic              key_hit
);
  key_step_e         step_q;
  logic [DATA_W-1:0] want;
  logic              match;

  always_comb begin
    unique case (step_q)
      KS_WAIT0: want = DATA_W'(KEY_B0);
      KS_WAIT1: want = DATA_W'(KEY_B1);
      KS_WAIT2: want = DATA_W'(KEY_B2);
      default:  want = alt_base ? DATA_W'(KEY_LAST_B) : DATA_W'(KEY_LAST_A);
    endcase
    match   = (key_byte == want);
    key_hit = key_we && match && (step_q == KS_WAIT3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= KS_WAIT0;
    end else if (key_we) begin
      if (match) begin
        unique case (step_q)
          KS_WAIT0: step_q <= KS_WAIT1;
          KS_WAIT1: step_q <= KS_WAIT2;
          KS_WAIT2: step_q <= KS_WAIT3;
          default:  step_q <= KS_WAIT0;
        endcase
      end else if (key_byte == DATA_W'(KEY_B0)) begin
        step_q <= KS_WAIT1;
      end else begin
        step_q <= KS_WAIT0;
      end
    end
  end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter logic [7:0]       ID_HI      = 8'h87,
  parameter logic [7:0]       ID_LO      = 8'h16,
  parameter logic [7:0]       REV_ID     = 8'h03,
  parameter logic [7:0]       FLASH_LDN  = 8'h07,
  parameter logic [7:0]       CTL_INIT   = 8'h02,
  parameter logic [15:0]      FBASE_INIT = 16'h0820
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   reg_idx,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rd_val,
  output logic                lock_req,
  output logic [DATA_W-1:0]   ldn_q,
  output logic [DATA_W-1:0]   ctl_q,
  output logic [2*DATA_W-1:0] fbase_q
);
  localparam int NBANK = 2;

  logic              in_flash_bank;
  logic [NBANK-1:0]  bank_sel;
  logic [DATA_W-1:0] bank_q [NBANK];

  assign in_flash_bank = (ldn_q == DATA_W'(FLASH_LDN));
  assign bank_sel[0]   = (reg_idx == DATA_W'(REG_FB_HI));
  assign bank_sel[1]   = (reg_idx == DATA_W'(REG_FB_LO));
  assign lock_req      = wr_en && (reg_idx == DATA_W'(REG_LOCK)) && wdata[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ldn_q <= '0;
      ctl_q <= DATA_W'(CTL_INIT);
    end else if (wr_en) begin
      if (reg_idx == DATA_W'(REG_LDN))  ldn_q <= wdata;
      if (reg_idx == DATA_W'(REG_FCTL)) ctl_q <= wdata;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int HI = (NBANK - b) * DATA_W - 1;
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[b] <= FBASE_INIT[HI -: DATA_W];
      end else if (wr_en && in_flash_bank && bank_sel[b]) begin
        bank_q[b] <= wdata;
      end
    end
    assign fbase_q[HI -: DATA_W] = bank_q[b];
  end

  always_comb begin
    rd_val = '0;
    unique case (reg_idx)
      DATA_W'(REG_ID_HI): rd_val = DATA_W'(ID_HI);
      DATA_W'(REG_ID_LO): rd_val = DATA_W'(ID_LO);
      DATA_W'(REG_REV):   rd_val = DATA_W'(REV_ID);
      DATA_W'(REG_LDN):   rd_val = ldn_q;
      DATA_W'(REG_FCTL):  rd_val = ctl_q;
      DATA_W'(REG_FB_HI): rd_val = in_flash_bank ? bank_q[0] : '0;
      DATA_W'(REG_FB_LO): rd_val = in_flash_bank ? bank_q[1] : '0;
      default:            rd_val = '0;
    endcase
  end
endmodule

// File: rtl/sio_cfg_gate.sv
module sio_cfg_gate
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  BASE_A     = 8'h2E,
  parameter logic [7:0]  BASE_B     = 8'h4E,
  parameter logic [7:0]  ID_HI      = 8'h87,
  parameter logic [7:0]  ID_LO      = 8'h16,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [7:0]  FLASH_LDN  = 8'h07,
  parameter logic [7:0]  CTL_INIT   = 8'h02,
  parameter logic [15:0] FBASE_INIT = 16'h0820
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                base_sel,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic [DATA_W-1:0]   io_wdata,
  output logic [DATA_W-1:0]   io_rdata,
  output logic                cfg_open,
  output logic [DATA_W-1:0]   ldn_sel,
  output logic [DATA_W-1:0]   flash_ctl,
  output logic [2*DATA_W-1:0] flash_base
);
  logic              hit_idx, hit_dat;
  logic              key_we, key_hit;
  logic              reg_we, lock_req;
  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] reg_rd;
  logic [DATA_W-1:0] rd_next;

  sio_port_decode #(
    .ADDR_W (ADDR_W),
    .BASE_A (BASE_A),
    .BASE_B (BASE_B)
  ) u_dec (
    .base_sel (base_sel),
    .addr     (io_addr),
    .hit_idx  (hit_idx),
    .hit_dat  (hit_dat)
  );

  assign key_we = io_wr && hit_idx && !cfg_open;
  assign reg_we = io_wr && hit_dat && cfg_open;

  sio_key_seq #(
    .DATA_W (DATA_W)
  ) u_key (
    .clk      (clk),
    .rst      (rst),
    .key_we   (key_we),
    .key_byte (io_wdata),
    .alt_base (base_sel),
    .key_hit  (key_hit)
  );

  sio_cfg_regs #(
    .DATA_W     (DATA_W),
    .ID_HI      (ID_HI),
    .ID_LO      (ID_LO),
    .REV_ID     (REV_ID),
    .FLASH_LDN  (FLASH_LDN),
    .CTL_INIT   (CTL_INIT),
    .FBASE_INIT (FBASE_INIT)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_we),
    .reg_idx  (idx_q),
    .wdata    (io_wdata),
    .rd_val   (reg_rd),
    .lock_req (lock_req),
    .ldn_q    (ldn_sel),
    .ctl_q    (flash_ctl),
    .fbase_q  (flash_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_open <= 1'b0;
    end else if (key_hit) begin
      cfg_open <= 1'b1;
    end else if (lock_req) begin
      cfg_open <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (io_wr && hit_idx && cfg_open) begin
      idx_q <= io_wdata;
    end
  end

  always_comb begin
    rd_next = DATA_W'(RD_IDLE);
    if (cfg_open && hit_idx)      rd_next = idx_q;
    else if (cfg_open && hit_dat) rd_next = reg_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= DATA_W'(RD_IDLE);
    end else if (io_rd) begin
      io_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/sio_cfg_gate_chk.sv
module sio_cfg_gate_chk #(
  parameter int         ADDR_W = 8,
  parameter int         DATA_W = 8,
  parameter logic [7:0] BASE_A = 8'h2E,
  parameter logic [7:0] BASE_B = 8'h4E,
  parameter logic [7:0] ID_HI  = 8'h87
) (
  input logic                clk,
  input logic                rst,
  input logic                base_sel,
  input logic                io_wr,
  input logic                io_rd,
  input logic [ADDR_W-1:0]   io_addr,
  input logic [DATA_W-1:0]   io_wdata,
  input logic [DATA_W-1:0]   io_rdata,
  input logic                cfg_open,
  input logic [DATA_W-1:0]   flash_ctl,
  input logic [2*DATA_W-1:0] flash_base,
  input logic [DATA_W-1:0]   idx_q
);
  logic [ADDR_W-1:0] a_idx, a_dat;
  assign a_idx = base_sel ? ADDR_W'(BASE_B) : ADDR_W'(BASE_A);
  assign a_dat = a_idx + ADDR_W'(1);

  p_locked_read_ff_r5: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !cfg_open) |=> (io_rdata == 8'hFF));

  p_locked_write_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == a_dat && !cfg_open) |=> ($stable(flash_ctl) && $stable(flash_base)));

  p_open_only_by_index_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(io_wr && io_addr == a_idx));

  p_relock_r10: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == a_dat && cfg_open && idx_q == 8'h02 && io_wdata[1]) |=> !cfg_open);

  p_id_read_r6: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == a_dat && cfg_open && idx_q == 8'h20) |=> (io_rdata == ID_HI));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

  p_foreign_read_r11: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr != a_idx && io_addr != a_dat) |=> (io_rdata == 8'hFF));
endmodule

bind sio_cfg_gate sio_cfg_gate_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BASE_A (BASE_A),
  .BASE_B (BASE_B),
  .ID_HI  (ID_HI)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .base_sel   (base_sel),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_addr    (io_addr),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .cfg_open   (cfg_open),
  .flash_ctl  (flash_ctl),
  .flash_base (flash_base),
  .idx_q      (idx_q)
);

// File: tb/test_sio_cfg_gate.sv
`timescale 1ns/1ps
module test_sio_cfg_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_sel = 1'b0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_addr = 8'h00;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        cfg_open;
  logic [7:0]  ldn_sel;
  logic [7:0]  flash_ctl;
  logic [15:0] flash_base;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  sio_cfg_gate i_sio_cfg_gate (
    .clk (clk), .rst (rst), .base_sel (base_sel),
    .io_wr (io_wr), .io_rd (io_rd), .io_addr (io_addr), .io_wdata (io_wdata),
    .io_rdata (io_rdata), .cfg_open (cfg_open), .ldn_sel (ldn_sel),
    .flash_ctl (flash_ctl), .flash_base (flash_base)
  );

  // Behavioural reference model
  bit        m_open;
  byte       hist[$];
  int        m_idx, m_ldn, m_ctl, m_fbh, m_fbl, m_rdata;

  function automatic int base_of(bit s);
    return s ? 'h4E : 'h2E;
  endfunction

  function automatic int model_reg(int r);
    case (r)
      'h20: return 'h87;
      'h21: return 'h16;
      'h22: return 'h03;
      'h07: return m_ldn;
      'h24: return m_ctl;
      'h64: return (m_ldn == 7) ? m_fbh : 0;
      'h65: return (m_ldn == 7) ? m_fbl : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int b;
    b = base_of(base_sel);
    if (rst) begin
      m_open = 0; hist.delete(); m_idx = 0; m_ldn = 0; m_ctl = 'h02;
      m_fbh = 'h08; m_fbl = 'h20; m_rdata = 'hFF;
    end else begin
      if (io_rd) begin
        if (m_open && io_addr == b) m_rdata = m_idx;
        else if (m_open && io_addr == b + 1) m_rdata = model_reg(m_idx);
        else m_rdata = 'hFF;
      end
      if (io_wr && io_addr == b) begin
        if (m_open) m_idx = io_wdata;
        else begin
          hist.push_back(io_wdata);
          if (hist.size() > 4) void'(hist.pop_front());
          if (hist.size() == 4 && hist[0] == 8'h87 && hist[1] == 8'h01 &&
              hist[2] == 8'h55 && hist[3] == (base_sel ? 8'hAA : 8'h55)) begin
            m_open = 1; hist.delete();
          end
        end
      end else if (io_wr && io_addr == b + 1 && m_open) begin
        case (m_idx)
          'h07: m_ldn = io_wdata;
          'h24: m_ctl = io_wdata;
          'h64: if (m_ldn == 7) m_fbh = io_wdata;
          'h65: if (m_ldn == 7) m_fbl = io_wdata;
          'h02: if (io_wdata[1]) m_open = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 model cfg_open", cfg_open, m_open);
      check("R12 model io_rdata", io_rdata, m_rdata);
      check("R7 model ldn_sel", ldn_sel, m_ldn);
      check("R9 model flash_ctl", flash_ctl, m_ctl);
      check("R8 model flash_base", flash_base, {m_fbh[7:0], m_fbl[7:0]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    io_wr = 1; io_addr = a[7:0]; io_wdata = d[7:0];
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    io_rd = 1; io_addr = a[7:0];
    @(negedge clk);
    io_rd = 0;
    v = io_rdata;
  endtask

  task automatic key(int b, int last);
    wr(b, 'h87); wr(b, 'h01); wr(b, 'h55); wr(b, last);
  endtask

  task automatic reg_wr(int b, int r, int d);
    wr(b, r); wr(b + 1, d);
  endtask

  task automatic reg_rd(int b, int r, output int v);
    wr(b, r); rd(b + 1, v);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset closed", cfg_open, 0);
    check("R1 reset flash_base", flash_base, 'h0820);
    check("R1 reset flash_ctl", flash_ctl, 'h02);
    check("R1 reset ldn", ldn_sel, 0);
    rd('h2F, v); check("R5 locked data read", v, 'hFF);
    rd('h2E, v); check("R5 locked index read", v, 'hFF);

    key('h2E, 'hAA);
    check("R3 wrong last byte", cfg_open, 0);
    key('h2E, 'h55);
    check("R2 unlock at 0x2E", cfg_open, 1);

    reg_rd('h2E, 'h20, v); check("R6 id hi", v, 'h87);
    reg_rd('h2E, 'h21, v); check("R6 id lo", v, 'h16);
    reg_rd('h2E, 'h22, v); check("R6 rev", v, 'h03);
    rd('h2E, v); check("R13 index readback", v, 'h22);
    reg_rd('h2E, 'h31, v); check("R13 unimplemented reads 0", v, 0);

    reg_wr('h2E, 'h07, 'h03);
    reg_rd('h2E, 'h07, v); check("R7 ldn readback", v, 'h03);
    reg_wr('h2E, 'h64, 'h12);
    reg_rd('h2E, 'h64, v); check("R8 bank hidden reads 0", v, 0);
    check("R8 bank write ignored", flash_base, 'h0820);
    reg_wr('h2E, 'h07, 'h07);
    reg_wr('h2E, 'h64, 'h0A);
    reg_wr('h2E, 'h65, 'h80);
    check("R8 flash_base written", flash_base, 'h0A80);
    reg_rd('h2E, 'h65, v); check("R8 low byte read", v, 'h80);

    reg_wr('h2E, 'h24, 'h3E);
    check("R9 flash_ctl", flash_ctl, 'h3E);
    reg_rd('h2E, 'h24, v); check("R9 ctl readback", v, 'h3E);

    wr('h60, 'h11); rd('h60, v); check("R11 foreign read", v, 'hFF);
    check("R11 foreign write no effect", flash_ctl, 'h3E);

    rd('h2F, v);
    repeat (4) @(negedge clk);
    check("R12 rdata held", io_rdata, v);

    reg_wr('h2E, 'h02, 'h01);
    check("R10 bit1 clear keeps open", cfg_open, 1);
    reg_wr('h2E, 'h02, 'h02);
    check("R10 relock", cfg_open, 0);

    wr('h2F, 'h00);
    check("R5 locked write ignored", flash_ctl, 'h3E);
    rd('h2F, v); check("R5 locked read after relock", v, 'hFF);

    wr('h2E, 'h87); wr('h2E, 'h01); wr('h2E, 'h87);
    wr('h2E, 'h01); wr('h2E, 'h55); wr('h2E, 'h55);
    check("R4 restart on 0x87", cfg_open, 1);
    reg_wr('h2E, 'h02, 'h02);
    wr('h2E, 'h87); wr('h2E, 'h01); wr('h2E, 'h33);
    wr('h2E, 'h55); wr('h2E, 'h55);
    check("R4 broken key stays closed", cfg_open, 0);

    base_sel = 1;
    key('h4E, 'h55);
    check("R3 0x55 on alt base", cfg_open, 0);
    key('h2E, 'hAA);
    check("R11 old base ignored", cfg_open, 0);
    key('h4E, 'hAA);
    check("R2 unlock at 0x4E", cfg_open, 1);
    reg_rd('h4E, 'h21, v); check("R6 id lo alt base", v, 'h16);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule